// File: doc/BRIEF.md
# Four-Channel PWM Compare Stage with Glitch Hold

The block counts clock cycles in a wide free-running counter, cuts a 16-bit window out of that counter according to a programmable scale, and compares the window against four programmable thresholds every clock. Each threshold drives one PWM output. The output is high while the window value is at or above the threshold. Two optional behaviours shape the waveform. In cycle-clear mode, threshold 0 ends the PWM period early, so the counter returns to zero. In hold mode, each output that has gone high stays high until the next period begins, so a threshold rewritten mid-period cannot produce a runt pulse.

Software programs the block through a plain register port with a write strobe, a byte address, write data and a combinational read-data bus. A two-state run controller gates the counter. In `ST_HALT` the counter keeps its value. In `ST_COUNT` it advances. Transition `T_START` (`ST_HALT` to `ST_COUNT`) is taken at the clock edge after the run bit is seen set. Transition `T_STOP` (`ST_COUNT` to `ST_HALT`) is taken at the clock edge after the run bit is seen clear. The state register updates on every edge. The state therefore trails the configuration by one clock, and the counter follows the state.

Top module: `pwm_compare_unit`

## Requirements
- R1: After reset, the settings word reads 0 at byte address 0x00, and the counter (0x08) and the scaled window (0x10) both read 0.
- R2: The counter adds 1 at each clock edge while the controller is in `ST_COUNT`. It holds its value in `ST_HALT`. The settings word has the run bit at bit 12. A write to address 0x08 loads the counter (bits [30:0]) and overrides counting.
- R3: The scaled window, readable at 0x10, is counter bits [scale+15:scale]. The scale is the settings word's bits [3:0].
- R4: Output i is high exactly when the window is greater than or equal to threshold i, while hold mode is off.
- R5: When cycle-clear mode is on (settings bit 8) and the window is at or above threshold 0 while counting, the counter is 0 after the next edge. With scale 0 and threshold N, the period is N+1 clocks.
- R6: When cycle-clear mode is off, passing threshold 0 does not clear the counter. The 31-bit counter rolls over from 0x7FFFFFFF to 0.
- R7: With hold mode on (settings bit 9), an output that has been high does not fall before the next period start, even if its threshold is raised above the window.
- R8: At each period start the held state is dropped. From the following clock each output again shows only the plain comparison.
- R9: With hold and cycle-clear both on and threshold 0 non-zero, output 0 is high for a single clock per period.
- R10: With hold on and cycle-clear off, a period starts when counter bits [scale+15:0] are all ones, which is the clock just before the window rolls to zero. Held outputs drop after that clock.
- R11: Thresholds 0 to 3 sit at 0x20, 0x24, 0x28 and 0x2C and store bits [15:0]. Bits [31:16] read 0. A threshold write takes effect at the next clock. Settings bits other than 12, 9, 8 and 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pwm_out | output | 4 | One PWM output per threshold |

## Verification
A stuck or mis-sequenced run controller shows on the next read of the counter as a value that failed to advance or failed to hold. A wrong cycle-clear decision shows within one clock of threshold 0 as a counter that keeps climbing or falls to zero too early. A held bit that is never set lets an output fall in the same clock in which its threshold is raised. A held bit that is never released keeps the output high on the first sample of the new period. So every internal fault this block can have becomes visible at `pwm_out` or `reg_rdata` within one or two clocks of the event that exposes it.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    localparam int CMP_W   = 16;
    localparam int CNT_W   = 31;
    localparam int SCALE_W = 4;
    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 8;

    localparam logic [7:0] ADR_CFG  = 8'h00;
    localparam logic [7:0] ADR_CNT  = 8'h08;
    localparam logic [7:0] ADR_SCL  = 8'h10;
    localparam logic [7:0] ADR_CMP0 = 8'h20;

    localparam int CFG_ZC_BIT   = 8;
    localparam int CFG_HOLD_BIT = 9;
    localparam int CFG_EN_BIT   = 12;

    typedef struct packed {
        logic               en;
        logic               hold;
        logic               zc;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
    import pwm_cmp_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int CW   = CMP_W,
    parameter int NW   = CNT_W,
    parameter int AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [NW-1:0] count,
    input  logic [CW-1:0] scaled,
    output cfg_t          cfg,
    output logic [CW-1:0] cmp_val [N_CH],
    output logic          cnt_load,
    output logic [NW-1:0] cnt_load_val,
    output logic [31:0]   rdata
);

    localparam logic [AW-1:0] CMP_FIRST = AW'(ADR_CMP0);
    localparam logic [AW-1:0] CMP_LAST  = AW'(ADR_CMP0) + AW'(4 * (N_CH - 1));

    // settings register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && addr == AW'(ADR_CFG)) begin
            cfg.scale <= wdata[SCALE_W-1:0];
            cfg.zc    <= wdata[CFG_ZC_BIT];
            cfg.hold  <= wdata[CFG_HOLD_BIT];
            cfg.en    <= wdata[CFG_EN_BIT];
        end
    end

    // threshold registers: no reset value, software programs them first
    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        localparam logic [AW-1:0] MY_ADR = AW'(ADR_CMP0) + AW'(4 * i);
        logic [CW-1:0] val_q;

        always_ff @(posedge clk) begin
            if (wr_en && addr == MY_ADR) begin
                val_q <= wdata[CW-1:0];
            end
        end

        assign cmp_val[i] = val_q;
    end

    assign cnt_load     = wr_en && (addr == AW'(ADR_CNT));
    assign cnt_load_val = wdata[NW-1:0];

    always_comb begin
        rdata = '0;
        if (addr == AW'(ADR_CFG)) begin
            rdata[SCALE_W-1:0]  = cfg.scale;
            rdata[CFG_ZC_BIT]   = cfg.zc;
            rdata[CFG_HOLD_BIT] = cfg.hold;
            rdata[CFG_EN_BIT]   = cfg.en;
        end else if (addr == AW'(ADR_CNT)) begin
            rdata = 32'(count);
        end else if (addr == AW'(ADR_SCL)) begin
            rdata = 32'(scaled);
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (addr == AW'(ADR_CMP0) + AW'(4 * i)) begin
                    rdata = 32'(cmp_val[i]);
                end
            end
        end
    end

    // R11: reserved upper bits of every threshold read back as zero
    property p_cmp_upper_zero;
        @(posedge clk) disable iff (!rst_n)
        (addr >= CMP_FIRST && addr <= CMP_LAST && addr[1:0] == 2'b00) |-> (rdata[31:CW] == '0);
    endproperty
    assert_cmp_upper_zero_R11: assert property (p_cmp_upper_zero);

    // R11: a settings write is visible on the next clock
    property p_cfg_takes_effect;
        @(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(ADR_CFG)) |=> (cfg.en == $past(wdata[CFG_EN_BIT]));
    endproperty
    assert_cfg_takes_effect_R11: assert property (p_cfg_takes_effect);

endmodule

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter
    import pwm_cmp_pkg::*;
#(
    parameter int CW = CMP_W,
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          load,
    input  logic [NW-1:0] load_val,
    input  logic          hit0,
    output logic [NW-1:0] count,
    output logic [CW-1:0] scaled,
    output logic          running,
    output logic          restart
);

    localparam logic [SCALE_W:0] SPAN = (SCALE_W + 1)'(NW - CW);

    run_state_e    state_q, state_d;
    logic [NW-1:0] shifted;
    logic [NW-1:0] carry_mask;
    logic [SCALE_W:0] mask_shift;
    logic          carry_out;
    logic          cycle_end;

    // run controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // run controller transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (cfg.en)  state_d = ST_COUNT;  // T_START
            ST_COUNT: if (!cfg.en) state_d = ST_HALT;   // T_STOP
            default:  state_d = ST_HALT;
        endcase
    end

    // run controller outputs and period logic
    always_comb begin
        running    = (state_q == ST_COUNT);
        shifted    = count >> cfg.scale;
        scaled     = shifted[CW-1:0];
        mask_shift = SPAN - {1'b0, cfg.scale};
        carry_mask = {NW{1'b1}} >> mask_shift;
        carry_out  = ((count & carry_mask) == carry_mask);
        cycle_end  = cfg.zc ? hit0 : carry_out;
        restart    = running && cycle_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (running) begin
            if (cfg.zc && hit0) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    // R2: advance by one per counting clock
    property p_step;
        @(posedge clk) disable iff (!rst_n)
        (running && !load && !(cfg.zc && hit0)) |=> (count == $past(count) + 1'b1);
    endproperty
    assert_step_R2: assert property (p_step);

    // R2: no movement while halted
    property p_hold_halt;
        @(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(count);
    endproperty
    assert_hold_halt_R2: assert property (p_hold_halt);

    // R5: threshold 0 reached in cycle-clear mode empties the counter
    property p_zero_clear;
        @(posedge clk) disable iff (!rst_n)
        (running && cfg.zc && hit0 && !load) |=> (count == '0);
    endproperty
    assert_zero_clear_R5: assert property (p_zero_clear);

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import pwm_cmp_pkg::*;
#(
    parameter int CW = CMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] scaled,
    input  logic [CW-1:0] thresh,
    input  logic          hold_en,
    input  logic          restart,
    output logic          hit,
    output logic          out
);

    logic held_q;

    assign hit = (scaled >= thresh);
    assign out = hit || (held_q && hold_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (!hold_en || restart) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held_q || hit;
        end
    end

    // R7: a high output stays high within the period
    property p_no_fall;
        @(posedge clk) disable iff (!rst_n)
        (hold_en && out && !restart) |=> (out || !hold_en);
    endproperty
    assert_no_fall_R7: assert property (p_no_fall);

    // R8: after a period start only the plain comparison remains
    property p_release;
        @(posedge clk) disable iff (!rst_n)
        restart |=> (out == hit);
    endproperty
    assert_release_R8: assert property (p_release);

endmodule

// File: rtl/pwm_compare_unit.sv
module pwm_compare_unit
    import pwm_cmp_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int CW   = CMP_W,
    parameter int NW   = CNT_W,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic [N_CH-1:0] pwm_out
);

    cfg_t          cfg;
    logic [CW-1:0] cmp_val [N_CH];
    logic          cnt_load;
    logic [NW-1:0] cnt_load_val;
    logic [NW-1:0] count;
    logic [CW-1:0] scaled;
    logic          running;
    logic          restart;
    logic [N_CH-1:0] hit;

    pwm_cmp_regs #(
        .N_CH (N_CH),
        .CW   (CW),
        .NW   (NW),
        .AW   (AW)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_we),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .count        (count),
        .scaled       (scaled),
        .cfg          (cfg),
        .cmp_val      (cmp_val),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .rdata        (reg_rdata)
    );

    pwm_cmp_counter #(
        .CW (CW),
        .NW (NW)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .hit0     (hit[0]),
        .count    (count),
        .scaled   (scaled),
        .running  (running),
        .restart  (restart)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pwm_cmp_channel #(
            .CW (CW)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .scaled  (scaled),
            .thresh  (cmp_val[i]),
            .hold_en (cfg.hold),
            .restart (restart),
            .hit     (hit[i]),
            .out     (pwm_out[i])
        );
    end

    // R9: with hold and cycle-clear, output 0 lasts one clock
    property p_single_pulse;
        @(posedge clk) disable iff (!rst_n)
        (running && cfg.zc && cfg.hold && hit[0] && cmp_val[0] != '0 && !reg_we)
            |=> !pwm_out[0];
    endproperty
    assert_single_pulse_R9: assert property (p_single_pulse);

endmodule

// File: tb/pwm_compare_unit_tb.sv
`timescale 1ns/1ps
module pwm_compare_unit_tb;

    localparam logic [31:0] C_EN   = 32'h0000_1000;
    localparam logic [31:0] C_HOLD = 32'h0000_0200;
    localparam logic [31:0] C_ZC   = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_compare_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic stop_and_load(input logic [31:0] c);
        wr(8'h00, 32'h0);
        wr(8'h08, c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk(v == 0, "R1 cfg", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 count", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 scaled", v, 0);
        repeat (5) @(negedge clk);
        rd(8'h08, v); chk(v == 0, "R2 halted after reset", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(8'h20, 32'h1111_0003); wr(8'h24, 32'h2222_0006);
        wr(8'h28, 32'hABCD_1234); wr(8'h2C, 32'hFFFF_5678);
        rd(8'h20, v); chk(v == 32'h3, "R11 cmp0", v, 32'h3);
        rd(8'h24, v); chk(v == 32'h6, "R11 cmp1", v, 32'h6);
        rd(8'h28, v); chk(v == 32'h1234, "R11 cmp2", v, 32'h1234);
        rd(8'h2C, v); chk(v == 32'h5678, "R11 cmp3", v, 32'h5678);
        wr(8'h00, 32'h0000_E3F7);
        rd(8'h00, v); chk(v == 32'h0307, "R11 cfg fields", v, 32'h0307);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        logic [31:0] held;
        wr(8'h20, 32'hFFFF); wr(8'h24, 32'hFFFF); wr(8'h28, 32'hFFFF); wr(8'h2C, 32'hFFFF);
        stop_and_load(0);
        wr(8'h00, C_EN);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            rd(8'h08, v); chk(v == k, "R2 increment", v, k);
            @(negedge clk);
        end
        wr(8'h00, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h08, held);
        repeat (5) @(negedge clk);
        rd(8'h08, v); chk(v == held, "R2 hold when stopped", v, held);
    endtask

    task automatic t_scale;
        logic [31:0] v;
        wr(8'h00, 32'h2); wr(8'h08, 32'h0001_234C);
        rd(8'h10, v); chk(v == 32'h48D3, "R3 scale 2", v, 32'h48D3);
        wr(8'h00, 32'hF); wr(8'h08, 32'h7FFF_8000);
        rd(8'h10, v); chk(v == 32'hFFFF, "R3 scale 15 top", v, 32'hFFFF);
        wr(8'h08, 32'h0000_7FFF);
        rd(8'h10, v); chk(v == 32'h0, "R3 scale 15 low", v, 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_compare;
        wr(8'h20, 32'h3); wr(8'h24, 32'h6); wr(8'h28, 32'h0); wr(8'h2C, 32'hFFFF);
        wr(8'h08, 32'h5);    chk(pwm_out == 4'b0101, "R4 count 5", 32'(pwm_out), 32'h5);
        wr(8'h08, 32'h6);    chk(pwm_out == 4'b0111, "R4 count 6", 32'(pwm_out), 32'h7);
        wr(8'h08, 32'hFFFF); chk(pwm_out == 4'b1111, "R4 count max", 32'(pwm_out), 32'hF);
        wr(8'h08, 32'h2);    chk(pwm_out == 4'b0100, "R4 count 2", 32'(pwm_out), 32'h4);
        wr(8'h08, 32'h5);
        wr(8'h24, 32'h5);    chk(pwm_out == 4'b0111, "R11 threshold next clock", 32'(pwm_out), 32'h7);
    endtask

    task automatic t_cycle_clear;
        logic [31:0] v;
        logic [31:0] exp;
        stop_and_load(0);
        wr(8'h20, 32'd9);
        wr(8'h00, C_EN | C_ZC);
        @(negedge clk);
        exp = 0;
        for (int k = 0; k < 25; k++) begin
            rd(8'h08, v); chk(v == exp, "R5 period from threshold 0", v, exp);
            exp = (exp >= 9) ? 0 : exp + 1;
            @(negedge clk);
        end
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        stop_and_load(8);
        wr(8'h00, C_EN);
        @(negedge clk);
        for (int k = 8; k < 12; k++) begin
            rd(8'h08, v); chk(v == k, "R6 no clear past threshold 0", v, k);
            @(negedge clk);
        end
        stop_and_load(32'h7FFF_FFFE);
        wr(8'h00, C_EN);
        @(negedge clk);
        rd(8'h08, v); chk(v == 32'h7FFF_FFFE, "R6 before rollover", v, 32'h7FFF_FFFE);
        @(negedge clk);
        rd(8'h08, v); chk(v == 32'h7FFF_FFFF, "R6 top", v, 32'h7FFF_FFFF);
        @(negedge clk);
        rd(8'h08, v); chk(v == 32'h0, "R6 rollover to zero", v, 32'h0);
    endtask

    task automatic t_hold(input bit hold);
        logic [31:0] v;
        bit seen_zero;
        stop_and_load(0);
        wr(8'h20, 32'd19); wr(8'h24, 32'd5);
        wr(8'h00, C_EN | C_ZC | (hold ? C_HOLD : 32'h0));
        for (int k = 0; k < 40; k++) begin
            rd(8'h08, v);
            if (v == 10) break;
            @(negedge clk);
        end
        wr(8'h24, 32'd15);
        seen_zero = 1'b0;
        for (int k = 0; k < 30; k++) begin
            rd(8'h08, v);
            if (v == 0) begin seen_zero = 1'b1; break; end
            if (hold)
                chk(pwm_out[1] == 1'b1, "R7 held output stays high", 32'(pwm_out[1]), 1);
            else
                chk(pwm_out[1] == (v >= 15), "R4 output follows new threshold", 32'(pwm_out[1]), 32'(v >= 15));
            @(negedge clk);
        end
        chk(seen_zero, "R5 period restart reached", 32'(seen_zero), 1);
        for (int k = 0; k < 17; k++) begin
            rd(8'h08, v);
            chk(pwm_out[1] == (v >= 15), "R8 plain comparison after restart", 32'(pwm_out[1]), 32'(v >= 15));
            @(negedge clk);
        end
    endtask

    task automatic t_single_pulse;
        logic [31:0] v;
        int highs;
        bit prev;
        stop_and_load(0);
        wr(8'h20, 32'd7); wr(8'h24, 32'hFFFF); wr(8'h28, 32'hFFFF); wr(8'h2C, 32'hFFFF);
        wr(8'h00, C_EN | C_ZC | C_HOLD);
        @(negedge clk);
        highs = 0; prev = 1'b0;
        for (int k = 0; k < 24; k++) begin
            rd(8'h08, v);
            chk(pwm_out[0] == (v == 7), "R9 output 0 only at threshold", 32'(pwm_out[0]), 32'(v == 7));
            if (pwm_out[0]) highs++;
            if (prev && pwm_out[0]) chk(1'b0, "R9 two-clock pulse", 1, 0);
            prev = pwm_out[0];
            @(negedge clk);
        end
        chk(highs == 3, "R9 one pulse per period", highs, 3);
    endtask

    task automatic t_carry;
        logic [31:0] v;
        bit reached;
        stop_and_load(32'h0001_FFF0);
        wr(8'h20, 32'hFFFF); wr(8'h24, 32'hFFFF); wr(8'h28, 32'h8000); wr(8'h2C, 32'hFFFF);
        wr(8'h00, C_EN | C_HOLD | 32'h1);
        wr(8'h28, 32'hFFFF);
        reached = 1'b0;
        for (int k = 0; k < 40; k++) begin
            rd(8'h08, v);
            if (v == 32'h0002_0000) begin
                reached = 1'b1;
                chk(pwm_out[2] == 1'b0, "R10 release after carry-out", 32'(pwm_out[2]), 0);
                break;
            end
            chk(pwm_out[2] == 1'b1, "R10 held until carry-out", 32'(pwm_out[2]), 1);
            @(negedge clk);
        end
        chk(reached, "R10 window rolled over", 32'(reached), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_scale();
        t_compare();
        t_cycle_clear();
        t_wrap();
        t_hold(1'b0);
        t_hold(1'b1);
        t_single_pulse();
        t_carry();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule